// File: doc/BRIEF.md
# Self-Starting Divide-by-Six Counter

This block is a three-bit synchronous counter that walks through the six codes 0 to 5 and then returns to 0. Three D-type state bits hold the count. Their contents drive the count output directly, with no decode in between. A combinational next-state table feeds each D input with the next-state bit it needs. The table also gives a successor for each of the two codes the sequence never uses, 6 and 7. Both of these lead straight back to 0, so the counter cannot settle in a loop outside its count sequence, whatever state it powers up in or is pushed into.

The named states are `ST_C0` through `ST_C5` for the counting codes, and `ST_X6` and `ST_X7` for the two unused codes. The transitions are named as follows:
- `ST_C0`→`ST_C1`→`ST_C2`→`ST_C3`→`ST_C4`→`ST_C5` is the step transition.
- `ST_C5`→`ST_C0` is the wrap.
- `ST_X6`→`ST_C0` and `ST_X7`→`ST_C0` are the recovery transitions.
- Any state→`ST_C0` while reset is high is the reset transition.

A terminal flag marks the last code of each cycle, so a neighbouring block can use the counter as a divide-by-six strobe.

Top module: `mod6_counter`

## Requirements
- R1: In the absence of reset, each rising clock edge moves the count from code n to n+1 for n in 0 to 4.
- R2: In the absence of reset, the rising edge seen with the count at 5 makes the next count 0.
- R3: The unused code 6 (binary 110) is followed by code 0 on the next rising edge.
- R4: The unused code 7 (binary 111) is followed by code 0 on the next rising edge.
- R5: A high `rst_i` sampled at a rising edge makes the count 0 after that edge, whatever the present code, and takes priority over counting. The count stays 0 for as long as reset is held.
- R6: From each of the eight possible three-bit codes, the state after one edge is a valid code in the range 0 to 5.
- R7: `term_o` is high exactly when the count is 5, and low for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| count_o | output | 3 | Present state of the counter, equal to the count |
| term_o | output | 1 | High while the count is 5 |

## Verification
The first corner case is the wrap from 5 to 0. A table that simply added one would step to 6 here and break the cycle length. The second is the pair of unused codes, which the bench drives straight into the next-state module. A table that left either code unmapped, or pointed it back at itself, would lock up the counter or give a code outside the range 0 to 5. Reset is applied in the middle of a count and held across several edges. A design that let counting win over reset would show a non-zero count there. The terminal flag is compared against the count at every step, so a flag decoded one code early or late would be reported.

// File: rtl/mod6_pkg.sv
package mod6_pkg;
    localparam int CNT_W     = 3;
    localparam int LAST_CODE = 5;

    typedef enum logic [CNT_W-1:0] {
        ST_C0 = 3'd0,
        ST_C1 = 3'd1,
        ST_C2 = 3'd2,
        ST_C3 = 3'd3,
        ST_C4 = 3'd4,
        ST_C5 = 3'd5,
        ST_X6 = 3'd6,
        ST_X7 = 3'd7
    } cnt_state_e;
endpackage

// File: rtl/mod6_next_state.sv
module mod6_next_state
    import mod6_pkg::*;
(
    input  logic [CNT_W-1:0] cur_i,
    output logic [CNT_W-1:0] nxt_o
);
    cnt_state_e cur;
    cnt_state_e nxt;

    assign cur = cnt_state_e'(cur_i);

    always_comb begin
        unique case (cur)
            ST_C0:   nxt = ST_C1;   // step
            ST_C1:   nxt = ST_C2;   // step
            ST_C2:   nxt = ST_C3;   // step
            ST_C3:   nxt = ST_C4;   // step
            ST_C4:   nxt = ST_C5;   // step
            ST_C5:   nxt = ST_C0;   // wrap
            ST_X6:   nxt = ST_C0;   // recovery
            ST_X7:   nxt = ST_C0;   // recovery
            default: nxt = ST_C0;
        endcase
    end

    assign nxt_o = nxt;

    always_comb begin
        if (cur_i == 3'd6 || cur_i == 3'd7) begin
            AST_UNUSED_RECOVER: assert (nxt_o == 3'd0);  // R3
        end
        AST_LEGAL_NEXT: assert (nxt_o <= 3'(LAST_CODE));  // R6
    end
endmodule

// File: rtl/mod6_state_reg.sv
module mod6_state_reg #(
    parameter int WIDTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_dbit
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                q_o[b] <= 1'b0;
            end else begin
                q_o[b] <= d_i[b];
            end
        end
    end
endmodule

// File: rtl/mod6_counter.sv
module mod6_counter
    import mod6_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CNT_W-1:0] count_o,
    output logic             term_o
);
    logic [CNT_W-1:0] state_q;
    logic [CNT_W-1:0] state_d;

    mod6_next_state u_next (
        .cur_i (state_q),
        .nxt_o (state_d)
    );

    mod6_state_reg #(.WIDTH(CNT_W)) u_reg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (state_d),
        .q_o   (state_q)
    );

    always_comb begin
        count_o = state_q;
        term_o  = (state_q == CNT_W'(LAST_CODE));
    end

    AST_STEP_UP:    assert property (@(posedge clk_i) disable iff (rst_i)
                        (count_o < 3'd5) |=> (count_o == $past(count_o) + 3'd1));  // R1
    AST_WRAP_ZERO:  assert property (@(posedge clk_i) disable iff (rst_i)
                        (count_o == 3'd5) |=> (count_o == 3'd0));  // R2
    AST_CODE7_OUT:  assert property (@(posedge clk_i) disable iff (rst_i)
                        (count_o == 3'd7) |=> (count_o == 3'd0));  // R4
    AST_RESET_WINS: assert property (@(posedge clk_i)
                        rst_i |=> (count_o == 3'd0));  // R5
    AST_TERM_FLAG:  assert property (@(posedge clk_i) disable iff (rst_i)
                        term_o |-> (count_o == 3'd5));  // R7
endmodule

// File: tb/mod6_counter_tb.sv
module mod6_counter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst;
    logic [2:0] count;
    logic       term;
    logic [2:0] ns_cur;
    logic [2:0] ns_nxt;

    int n_checks = 0;
    int n_fail   = 0;

    mod6_counter dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .count_o (count),
        .term_o  (term)
    );

    mod6_next_state ns_i (
        .cur_i (ns_cur),
        .nxt_o (ns_nxt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        chk("R5 reset count", count, 0);
        chk("R7 term at 0", term, 0);
        step();
        chk("R5 reset held", count, 0);
        rst = 1'b0;
    endtask

    task automatic t_run(input int cycles);
        int exp = count;
        for (int i = 0; i < cycles; i++) begin
            step();
            if (exp == 5) begin
                exp = 0;
                chk("R2 wrap", count, exp);
            end else begin
                exp = exp + 1;
                chk("R1 step", count, exp);
            end
            chk("R7 term flag", term, (exp == 5) ? 1 : 0);
        end
    endtask

    task automatic t_midcount_reset();
        t_run(3);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R5 reset priority", count, 0);
        end
        rst = 1'b0;
        step();
        chk("R1 after reset", count, 1);
    endtask

    task automatic t_all_codes();
        for (int c = 0; c < 8; c++) begin
            int exp = (c >= 5) ? 0 : c + 1;
            ns_cur = 3'(c);
            #1;
            if (c == 6)      chk("R3 code 6 recovery", ns_nxt, exp);
            else if (c == 7) chk("R4 code 7 recovery", ns_nxt, exp);
            else             chk("R6 next-state table", ns_nxt, exp);
            chk("R6 legal next", (ns_nxt <= 3'd5) ? 1 : 0, 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst    = 1'b1;
        ns_cur = 3'd0;
        @(negedge clk);
        t_reset();
        t_run(14);
        t_midcount_reset();
        t_run(8);
        t_all_codes();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule